// File: doc/BRIEF.md
# Latency-Hiding Warp Scheduler

This block tracks the status of every resident warp of one compute cluster and, each clock cycle, picks one warp to issue its next instruction. A warp that issues a long-latency load is parked until a completion event for that warp arrives. Because each warp's register state stays in place, moving from one warp to another costs no cycles: the scheduler can issue a different warp in every cycle, and a parked warp's slot is filled at once by another ready warp.

Warps become resident through an allocate port and leave through a free port. Each warp has an instruction-valid flag from the fetch side. The issued instruction is marked as a load through a single flag that applies to the warp chosen in the same cycle. Selection among eligible warps is round-robin, starting with the warp after the one that issued last, so no warp starves. Fetch, decode and execution lie outside the block.

Top module: `warp_sched`

## Requirements
- R1: A warp is issued only when it is resident, in the READY state (not waiting on a load) and its instruction-valid bit is high.
- R2: At most one warp issues per cycle, and `issue_id` names that warp while `issue_valid` is high; outputs are combinational from the current state and inputs.
- R3: When a warp issues with `issue_is_load` high, it is in the waiting state from the next cycle, and in that next cycle another eligible warp issues with no idle cycle in between.
- R4: A completion (`done_valid`, `done_id`) for a waiting warp makes it eligible for issue in the very next cycle.
- R5: Among eligible warps the one chosen is the first found scanning upward (with wrap-around) from the warp after the last issued one; after reset the scan starts at warp 0.
- R6: `stall` is high, and `issue_valid` low, in exactly those cycles in which no warp is eligible.
- R7: If a completion names the warp that is issuing a load in the same cycle, the completion wins: the warp stays READY and no error is raised.
- R8: A completion for a warp that is not waiting (and not covered by R7), or for an ID at or above the warp count, changes no warp state and sets `done_err`, which stays high until reset.
- R9: An allocate makes the named warp resident and READY; a free makes it non-resident so it is never issued; a free in the same cycle as an allocate of the same warp wins.
- R10: After reset no warp is resident, `stall` is high, `issue_valid` and `done_err` are low, and reset is applied asynchronously and released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Make warp `alloc_id` resident and READY |
| alloc_id | input | WID_W | Warp to allocate |
| free_valid | input | 1 | Remove warp `free_id` from the resident set |
| free_id | input | WID_W | Warp to free |
| inst_valid | input | NUM_WARPS | Per-warp flag: next instruction available |
| issue_is_load | input | 1 | The instruction issued this cycle is a load |
| done_valid | input | 1 | Load data returned for warp `done_id` |
| done_id | input | WID_W | Warp whose load completed |
| issue_valid | output | 1 | A warp issues this cycle |
| issue_id | output | WID_W | Warp that issues this cycle |
| stall | output | 1 | No warp is eligible this cycle |
| done_err | output | 1 | Sticky flag: a completion arrived for a warp not waiting |

## Verification
The hardest situation to reach is the one where a completion names exactly the warp that is issuing a load in the same cycle, since the bench cannot know which warp wins arbitration without predicting the round-robin order. The stimulus uses a reference model of the requirements that computes the expected winner before driving the cycle, so the completion ID and the load flag are both aimed at the predicted warp. The all-waiting stall is reached by marking every issued instruction as a load until the pool is empty, and a long random phase then mixes allocation, freeing, loads and completions against the same model.

// File: rtl/ws_pkg.sv
package ws_pkg;

  // Per-warp scheduling state
  typedef enum logic [1:0] {
    WS_ABSENT  = 2'b00,
    WS_READY   = 2'b01,
    WS_MEMWAIT = 2'b10
  } warp_state_e;

  localparam int DEFAULT_WARPS = 48;

endpackage

// File: rtl/ws_warp_slot.sv
module ws_warp_slot
  import ws_pkg::*;
(
  input  logic clk,
  input  logic rst_ni,
  input  logic alloc_hit,
  input  logic free_hit,
  input  logic park,
  input  logic wake,
  input  logic inst_valid,
  output logic eligible,
  output logic waiting
);

  warp_state_e st_q;
  warp_state_e st_d;

  always_comb begin
    st_d = st_q;
    if (alloc_hit) begin
      st_d = WS_READY;
    end
    if (park && (st_d == WS_READY)) begin
      st_d = WS_MEMWAIT;
    end
    if (wake && (st_d == WS_MEMWAIT)) begin
      st_d = WS_READY;
    end
    if (free_hit) begin
      st_d = WS_ABSENT;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= WS_ABSENT;
    end else begin
      st_q <= st_d;
    end
  end

  assign eligible = (st_q == WS_READY) && inst_valid;
  assign waiting  = (st_q == WS_MEMWAIT);

  AST_PARK_TAKES: assert property (@(posedge clk) disable iff (!rst_ni)
    (park && eligible && !free_hit && !alloc_hit) |=> waiting); // R3

  AST_WAKE_RETURNS: assert property (@(posedge clk) disable iff (!rst_ni)
    (wake && waiting && !free_hit) |=> (st_q == WS_READY)); // R4

endmodule

// File: rtl/ws_rr_pick.sv
module ws_rr_pick #(
  parameter int NUM_WARPS = 48,
  parameter int WID_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic [NUM_WARPS-1:0] req,
  input  logic [WID_W-1:0]     last_id,
  output logic                 gnt_valid,
  output logic [WID_W-1:0]     gnt_id
);

  logic [NUM_WARPS-1:0] above;
  logic [NUM_WARPS-1:0] req_hi;
  logic [WID_W-1:0]     id_hi;
  logic [WID_W-1:0]     id_any;

  genvar g;
  generate
    for (g = 0; g < NUM_WARPS; g++) begin : g_mask
      assign above[g] = (WID_W'(g) > last_id);
    end
  endgenerate

  assign req_hi = req & above;

  // Lowest set index: scan downward, later hits overwrite earlier ones
  always_comb begin
    id_hi  = '0;
    id_any = '0;
    for (int i = NUM_WARPS - 1; i >= 0; i--) begin
      if (req_hi[i]) id_hi  = WID_W'(i);
      if (req[i])    id_any = WID_W'(i);
    end
  end

  assign gnt_valid = |req;
  assign gnt_id    = (|req_hi) ? id_hi : id_any;

  AST_GRANT_IS_REQ: assert property (@(posedge clk) disable iff (!rst_ni)
    gnt_valid |-> req[gnt_id]); // R1

  AST_GRANT_WHEN_ANY: assert property (@(posedge clk) disable iff (!rst_ni)
    (|req) |-> gnt_valid); // R6

endmodule

// File: rtl/warp_sched.sv
module warp_sched
  import ws_pkg::*;
#(
  parameter int NUM_WARPS = ws_pkg::DEFAULT_WARPS,
  parameter int WID_W     = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 alloc_valid,
  input  logic [WID_W-1:0]     alloc_id,
  input  logic                 free_valid,
  input  logic [WID_W-1:0]     free_id,
  input  logic [NUM_WARPS-1:0] inst_valid,
  input  logic                 issue_is_load,
  input  logic                 done_valid,
  input  logic [WID_W-1:0]     done_id,
  output logic                 issue_valid,
  output logic [WID_W-1:0]     issue_id,
  output logic                 stall,
  output logic                 done_err
);

  localparam logic [WID_W-1:0] START_LAST = WID_W'(NUM_WARPS - 1);

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_i = rst_sync_q[1];

  logic [NUM_WARPS-1:0] alloc_dec;
  logic [NUM_WARPS-1:0] free_dec;
  logic [NUM_WARPS-1:0] done_dec;
  logic [NUM_WARPS-1:0] issue_dec;
  logic [NUM_WARPS-1:0] park_dec;
  logic [NUM_WARPS-1:0] eligible;
  logic [NUM_WARPS-1:0] waiting;

  genvar g;
  generate
    for (g = 0; g < NUM_WARPS; g++) begin : g_slot
      assign alloc_dec[g] = alloc_valid && (alloc_id == WID_W'(g));
      assign free_dec[g]  = free_valid  && (free_id  == WID_W'(g));
      assign done_dec[g]  = done_valid  && (done_id  == WID_W'(g));
      assign issue_dec[g] = issue_valid && (issue_id == WID_W'(g));
      // A completion in the same cycle cancels the park
      assign park_dec[g]  = issue_dec[g] && issue_is_load && !done_dec[g];

      ws_warp_slot u_slot (
        .clk        (clk),
        .rst_ni     (rst_i),
        .alloc_hit  (alloc_dec[g]),
        .free_hit   (free_dec[g]),
        .park       (park_dec[g]),
        .wake       (done_dec[g]),
        .inst_valid (inst_valid[g]),
        .eligible   (eligible[g]),
        .waiting    (waiting[g])
      );
    end
  endgenerate

  // Last issued warp, the round-robin origin
  logic [WID_W-1:0] last_q;
  logic [WID_W-1:0] last_d;
  logic             last_en;

  assign last_en = issue_valid;
  assign last_d  = issue_id;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      last_q <= START_LAST;
    end else if (last_en) begin
      last_q <= last_d;
    end
  end

  ws_rr_pick #(
    .NUM_WARPS (NUM_WARPS),
    .WID_W     (WID_W)
  ) u_pick (
    .clk       (clk),
    .rst_ni    (rst_i),
    .req       (eligible),
    .last_id   (last_q),
    .gnt_valid (issue_valid),
    .gnt_id    (issue_id)
  );

  assign stall = !issue_valid;

  // Completion legality and sticky error
  logic done_ok;
  logic err_q;
  logic err_d;
  logic err_en;

  assign done_ok = |(done_dec & (waiting | (issue_dec & {NUM_WARPS{issue_is_load}})));
  assign err_en  = done_valid && !done_ok;
  assign err_d   = 1'b1;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign done_err = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_i)
    done_err |=> done_err); // R8

  AST_NOT_WAITING: assert property (@(posedge clk) disable iff (!rst_i)
    issue_valid |-> !waiting[issue_id]); // R1

  AST_FRESH_WAKE: assert property (@(posedge clk) disable iff (!rst_i)
    (issue_valid && issue_is_load && done_dec[issue_id] && !free_dec[issue_id])
      |=> !waiting[$past(issue_id)]); // R7

endmodule

// File: tb/tb_warp_sched.sv
`timescale 1ns/1ps
module tb_warp_sched;

  localparam int N  = 8;
  localparam int W  = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         alloc_valid;
  logic [W-1:0] alloc_id;
  logic         free_valid;
  logic [W-1:0] free_id;
  logic [N-1:0] inst_valid;
  logic         issue_is_load;
  logic         done_valid;
  logic [W-1:0] done_id;
  logic         issue_valid;
  logic [W-1:0] issue_id;
  logic         stall;
  logic         done_err;

  always #2.5 clk = ~clk;

  warp_sched #(.NUM_WARPS(N), .WID_W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_id(alloc_id),
    .free_valid(free_valid), .free_id(free_id),
    .inst_valid(inst_valid), .issue_is_load(issue_is_load),
    .done_valid(done_valid), .done_id(done_id),
    .issue_valid(issue_valid), .issue_id(issue_id),
    .stall(stall), .done_err(done_err)
  );

  typedef struct {
    string tag;
    bit    v;
    int    id;
    bit    st;
    bit    err;
  } exp_t;

  exp_t q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   finished = 0;

  // Reference model state
  bit m_res [N];
  bit m_wait[N];
  int m_last;
  bit m_err;

  // Staged stimulus for the next step
  bit s_alloc; int s_alloc_id;
  bit s_free;  int s_free_id;
  bit s_done;  int s_done_id;
  bit s_done_on_issue;
  int s_load_warp;   // -1 none, -2 every issue, else a warp
  logic [N-1:0] s_iv;

  function automatic void model_reset();
    for (int i = 0; i < N; i++) begin m_res[i] = 0; m_wait[i] = 0; end
    m_last = N - 1;
    m_err  = 0;
  endfunction

  function automatic void clear_stage();
    s_alloc = 0; s_free = 0; s_done = 0; s_done_on_issue = 0;
    s_alloc_id = 0; s_free_id = 0; s_done_id = 0; s_load_warp = -1;
  endfunction

  task automatic step(input string tag);
    exp_t e;
    int   pick;
    bit   ld;
    bit   coinc;
    @(negedge clk);
    pick = -1;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (m_last + k) % N;
      if (pick < 0 && m_res[idx] && !m_wait[idx] && s_iv[idx]) pick = idx;
    end
    ld = (pick >= 0) && ((s_load_warp == -2) || (s_load_warp == pick));
    if (s_done_on_issue && pick >= 0) s_done_id = pick;
    alloc_valid   = s_alloc; alloc_id = W'(s_alloc_id);
    free_valid    = s_free;  free_id  = W'(s_free_id);
    done_valid    = s_done || (s_done_on_issue && pick >= 0);
    done_id       = W'(s_done_id);
    inst_valid    = s_iv;
    issue_is_load = ld;
    e.tag = tag; e.v = (pick >= 0); e.id = pick; e.st = (pick < 0); e.err = m_err;
    q.push_back(e);
    // next state
    coinc = done_valid && ld && (s_done_id == pick);
    if (done_valid && !coinc && !m_wait[s_done_id]) m_err = 1;
    if (s_alloc) begin m_res[s_alloc_id] = 1; m_wait[s_alloc_id] = 0; end
    if (ld && !coinc) m_wait[pick] = 1;
    if (done_valid) m_wait[s_done_id] = 0;
    if (s_free) begin m_res[s_free_id] = 0; m_wait[s_free_id] = 0; end
    if (pick >= 0) m_last = pick;
    clear_stage();
  endtask

  // Monitor: compares once per cycle, after inputs settle, before the edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        bit   bad;
        e = q.pop_front();
        n_vec++;
        bad = (issue_valid !== e.v) || (stall !== e.st) || (done_err !== e.err) ||
              (e.v && (int'(issue_id) != e.id));
        if (bad) begin
          n_fail++;
          $display("FAIL %s: got v=%0b id=%0d stall=%0b err=%0b, expected v=%0b id=%0d stall=%0b err=%0b",
                   e.tag, issue_valid, issue_id, stall, done_err, e.v, e.id, e.st, e.err);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    alloc_valid = 0; alloc_id = '0; free_valid = 0; free_id = '0;
    inst_valid = '0; issue_is_load = 0; done_valid = 0; done_id = '0;
    model_reset();
    clear_stage();
    s_iv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state, including the synchronizer cycles
    repeat (3) step("R10");

    // R9: allocate warps 0..3 with no instructions
    for (int i = 0; i < 4; i++) begin
      s_alloc = 1; s_alloc_id = i; step("R9");
    end
    // R1: resident and ready, but no instruction valid
    s_iv = 8'h00; step("R1");
    s_iv = 8'b0000_0101; step("R1"); step("R1");
    // R5: round robin from warp 0 across four warps
    s_iv = 8'hFF;
    repeat (6) step("R5");
    // R3: warp 2 parks on a load, others continue without a gap
    s_load_warp = 2; step("R3");
    s_load_warp = 2; step("R3");
    s_load_warp = 2; step("R3");
    repeat (4) step("R3");
    // R4: completion for warp 2, issued again next turn
    s_done = 1; s_done_id = 2; step("R4");
    repeat (4) step("R4");
    // R7: completion on the warp that issues a load this cycle
    s_done_on_issue = 1; s_load_warp = -2; step("R7");
    repeat (4) step("R7");
    // R6: every issue is a load until the pool is empty
    for (int i = 0; i < 6; i++) begin s_load_warp = -2; step("R6"); end
    step("R6");
    // R4: all wake together, then round robin resumes
    for (int i = 0; i < 4; i++) begin s_done = 1; s_done_id = i; step("R4"); end
    // R8: completion for a ready warp is ignored and latches the error
    s_iv = 8'h00;
    s_done = 1; s_done_id = 1; step("R8");
    s_iv = 8'hFF;
    repeat (5) step("R8");
    // R9: free warp 1, never selected afterwards; alloc+free same cycle
    s_free = 1; s_free_id = 1; step("R9");
    repeat (4) step("R9");
    s_alloc = 1; s_alloc_id = 6; s_free = 1; s_free_id = 6; step("R9");
    repeat (4) step("R9");

    // Reset again, then the random phase
    @(negedge clk); rst_n = 1'b0;
    model_reset();
    @(negedge clk); rst_n = 1'b1;
    repeat (3) step("R10");
    for (int c = 0; c < 600; c++) begin
      int r;
      r = $urandom_range(0, 99);
      s_iv = N'($urandom);
      if (r < 25) begin s_alloc = 1; s_alloc_id = $urandom_range(0, N-1); end
      if (r > 90) begin s_free = 1; s_free_id = $urandom_range(0, N-1); end
      if ($urandom_range(0, 99) < 35) begin s_done = 1; s_done_id = $urandom_range(0, N-1); end
      if ($urandom_range(0, 99) < 40) s_load_warp = -2;
      step("R2");
    end

    repeat (2) @(negedge clk);
    #3;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule